// File: doc/BRIEF.md
# Transmit-Only Serial Byte Streamer

This block drives the serial output of a 128-byte identification memory at power-up. It does not use any bus protocol. A dedicated transmit clock, sampled on the system clock, paces the output. The line is released for the first nine rising edges of that clock, which serve as a synchronisation preamble. From the tenth edge on, the block sends the memory contents one byte at a time, starting at address zero. Each byte is a nine-slot frame: eight data bits, most significant first, then one slot in which the line is released. The address advances after every byte and wraps from the top location back to zero.

The data line is open-drain. The block only asserts an output-enable that pulls the line low, and it does so only for zero bits. A falling edge on the sampled two-wire clock input moves the block into bidirectional mode. A mode flag reports this to the bidirectional slave controller. From then on the block releases the line, ignores the transmit clock and freezes its read address. Only reset clears the flag.

The memory array sits outside this block. It is read through a combinational address/data port.

Top module: `txonly_streamer`

## Requirements
- R1: While reset is asserted and right after it, sdaOe is 0, biMode is 0 and memAddr is 0.
- R2: During the first nine transmit-clock rising edges after reset, sdaOe stays 0.
- R3: The tenth rising edge starts the frame of the byte at address 0: sdaOe becomes the inverse of that byte's bit 7.
- R4: Each later rising edge moves to the next lower bit. A data bit of value 0 gives sdaOe = 1, and a data bit of value 1 gives sdaOe = 0.
- R5: The ninth slot of every frame, after bit 0, keeps sdaOe at 0.
- R6: memAddr holds the address of the next byte to fetch. It steps by exactly one, and does so when a new frame starts.
- R7: After the byte at address 127, streaming goes on with the byte at address 0.
- R8: A falling edge of the synchronised sclIn sets biMode. biMode then stays 1 until reset.
- R9: While biMode is 1, sdaOe is 0, and transmit-clock edges leave memAddr unchanged.
- R10: A change on txClk or sclIn shows on the outputs at the third system-clock rising edge after it, not earlier (two synchroniser flops plus one state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txClk | input | 1 | Asynchronous transmit clock that paces streaming |
| sclIn | input | 1 | Asynchronous two-wire clock line; a falling edge hands control over |
| memData | input | 8 | Read data for memAddr, valid in the same cycle |
| memAddr | output | 7 | Address of the next byte to fetch |
| sdaOe | output | 1 | Open-drain pull-low enable for the data line |
| biMode | output | 1 | Sticky flag: bidirectional mode is active |

## Verification
The assertions assume that txClk and sclIn each hold every level for at least three system clocks. Without that, the synchroniser could merge or drop edges, and the preamble count would no longer match the rising edges the bench applies. The assertions also assume that sclIn is high (idle) when reset is released, unless the stimulus means to switch mode at once. The bench holds each transmit-clock level for three cycles and changes inputs only on falling system-clock edges. It drops sclIn only when it means to leave streaming, including one run where the line is low straight out of reset.

// File: rtl/txonly_streamer_pkg.sv
package txonly_streamer_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // fetch next byte and advance address
    logic shift;  // advance to next lower bit
    logic drive;  // current slot carries a data bit
  } strobeT;

endpackage

// File: rtl/txs_edge_sync.sv
module txs_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0,
  parameter bit   RISING    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic edgeSeen
);

  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {CHAIN_W{RESET_VAL}};
    else        chain <= {chain[CHAIN_W-2:0], rawIn};
  end

  generate
    if (RISING) begin : g_rise
      assign edgeSeen = chain[STAGES-1] & ~chain[STAGES];
    end else begin : g_fall
      assign edgeSeen = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txonly_streamer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PRE_PULSES = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   txRise,
  input  logic   sclFall,
  output strobeT strobe,
  output logic   biMode
);

  localparam int CNT_W = $clog2(PRE_PULSES + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_PULSES);
  localparam logic [BIT_W-1:0] SLOT_LAST = BIT_W'(DATA_W);

  logic [CNT_W-1:0] preCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             started;
  logic             biModeQ;
  logic             act;

  assign act = txRise & ~biModeQ;

  always_comb begin
    strobe.load  = act & ((~started & (preCnt == PRE_LAST)) |
                          (started & (bitIdx == SLOT_LAST)));
    strobe.shift = act & started & (bitIdx != SLOT_LAST);
    strobe.drive = started & ~biModeQ & (bitIdx < SLOT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      bitIdx  <= '0;
      started <= 1'b0;
      biModeQ <= 1'b0;
    end else begin
      if (sclFall) biModeQ <= 1'b1;
      if (act) begin
        if (!started) begin
          if (preCnt == PRE_LAST) begin
            started <= 1'b1;
            bitIdx  <= '0;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end else if (bitIdx == SLOT_LAST) begin
          bitIdx <= '0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  assign biMode = biModeQ;

endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txonly_streamer_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              pullLow
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '1;
      fetchAddr <= '0;
    end else if (strobe.load) begin
      shiftReg  <= rdData;
      fetchAddr <= fetchAddr + 1'b1;
    end else if (strobe.shift) begin
      shiftReg  <= {shiftReg[DATA_W-2:0], 1'b1};
    end
  end

  assign pullLow = strobe.drive & ~shiftReg[DATA_W-1];

endmodule

// File: rtl/txonly_streamer.sv
module txonly_streamer
  import txonly_streamer_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PRE_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txClk,
  input  logic              sclIn,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sdaOe,
  output logic              biMode
);

  logic   txRise;
  logic   sclFall;
  strobeT strobe;

  txs_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .RISING(1'b1)) u_txSync (
    .clk(clk), .rst_n(rst_n), .rawIn(txClk), .edgeSeen(txRise));

  txs_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .RISING(1'b0)) u_sclSync (
    .clk(clk), .rst_n(rst_n), .rawIn(sclIn), .edgeSeen(sclFall));

  txs_ctrl #(.DATA_W(DATA_W), .PRE_PULSES(PRE_PULSES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txRise(txRise), .sclFall(sclFall),
    .strobe(strobe), .biMode(biMode));

  txs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdData(memData),
    .fetchAddr(memAddr), .pullLow(sdaOe));

endmodule

// File: rtl/txonly_streamer_chk.sv
module txonly_streamer_chk #(
  parameter int ADDR_W     = 7,
  parameter int PRE_PULSES = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txRise,
  input logic              sclFall,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sdaOe,
  input logic              biMode
);

  localparam int CNT_W = $clog2(PRE_PULSES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PRE_PULSES + 1);

  logic [CNT_W-1:0] riseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) riseCnt <= '0;
    else if (txRise && !biMode && riseCnt != CNT_SAT) riseCnt <= riseCnt + 1'b1;
  end

  assert_preamble_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (riseCnt < CNT_SAT) |-> !sdaOe);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (memAddr != $past(memAddr)) |-> (memAddr == $past(memAddr) + 1'b1));

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    biMode |=> biMode);

  assert_mode_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(biMode) |-> $past(sclFall));

  assert_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    biMode |-> !sdaOe);

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    biMode |=> $stable(memAddr));

endmodule

bind txonly_streamer txonly_streamer_chk #(.ADDR_W(ADDR_W), .PRE_PULSES(PRE_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .txRise(txRise), .sclFall(sclFall),
  .memAddr(memAddr), .sdaOe(sdaOe), .biMode(biMode));

// File: tb/txonly_streamer_tb.sv
module txonly_streamer_tb;

  logic       clk = 1'b0;
  logic       rst_n, txClk, sclIn;
  logic [7:0] memData;
  logic [6:0] memAddr;
  logic       sdaOe, biMode;
  logic [7:0] mem [128];
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  txonly_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .txClk(txClk), .sclIn(sclIn),
    .memData(memData), .memAddr(memAddr), .sdaOe(sdaOe), .biMode(biMode));

  assign memData = mem[memAddr];

  // spot-check table: byte index to verify in full while streaming
  localparam int SPOT [8] = '{0, 1, 2, 3, 64, 125, 126, 127};

  function automatic logic [7:0] memPat(int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  function automatic bit isSpot(int b);
    for (int s = 0; s < 8; s++) if (SPOT[s] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic txRiseWait();
    @(negedge clk) txClk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic txFallWait();
    txClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 128; a++) mem[a] = memPat(a);
    rst_n = 1'b0; txClk = 1'b0; sclIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sdaOe in reset", sdaOe, 0);
    check("R1 biMode in reset", biMode, 0);
    check("R1 memAddr in reset", memAddr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 9; p++) begin
      txRiseWait();
      check("R2 preamble silent", sdaOe, 0);
      check("R2 preamble addr", memAddr, 0);
      txFallWait();
    end

    for (int b = 0; b < 130; b++) begin
      for (int i = 0; i < 9; i++) begin
        logic [7:0] bt;
        int expOe;
        bt = memPat(b % 128);
        expOe = (i < 8) ? int'(!bt[7 - i]) : 0;
        if (b == 0 && i == 0) begin
          @(negedge clk) txClk = 1'b1;
          repeat (2) @(negedge clk);
          check("R10 no early change", sdaOe, 0);
          @(negedge clk);
          check("R3 first MSB at address 0", sdaOe, expOe);
        end else begin
          txRiseWait();
        end
        if (isSpot(b % 128) || b >= 127)
          check((b >= 127) ? "R7 wrap stream bit" : ((i < 8) ? "R4 data bit" : "R5 slot released"),
                sdaOe, expOe);
        if (i == 0)
          check((b >= 127) ? "R7 wrap address" : "R6 next fetch address", memAddr, (b + 1) % 128);
        txFallWait();
      end
    end

    begin
      bit seen;
      logic [6:0] savedAddr;
      seen = 1'b0;
      for (int k = 0; k < 9 && !seen; k++) begin
        txRiseWait();
        seen = sdaOe;
        if (!seen) txFallWait();
      end
      check("R4 zero bit pulls low", int'(seen), 1);
      @(negedge clk) sclIn = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 scl not early", biMode, 0);
      @(negedge clk);
      check("R8 scl fall sets biMode", biMode, 1);
      check("R9 released in biMode", sdaOe, 0);
      savedAddr = memAddr;
      txFallWait();
      for (int k = 0; k < 3; k++) begin
        txRiseWait();
        check("R9 released on tx edge", sdaOe, 0);
        txFallWait();
      end
      check("R9 address frozen", memAddr, savedAddr);
      sclIn = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 biMode sticky", biMode, 1);
    end

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset clears biMode", biMode, 0);
    check("R1 reset clears address", memAddr, 0);
    sclIn = 1'b0;
    rst_n = 1'b1;
    for (int p = 0; p < 11; p++) begin
      txRiseWait();
      check("R9 no output after early scl low", sdaOe, 0);
      txFallWait();
    end
    check("R8 early scl low sets biMode", biMode, 1);
    check("R9 address held at 0", memAddr, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule